// File: doc/BRIEF.md
# DMA Request Sampling Controller

This block sits in front of a DMA channel. It watches an active-low, asynchronous request pin and decides, in each clock, whether the pin is looked at and whether the value it sees grants a new transfer. Where the pin is looked at depends on three static settings: burst or cycle-steal transfer, edge or level detection, and single or dual address operation. The bus sequencer around it supplies a state strobe (one pulse per bus state), markers for the start and end of a bus cycle, a marker for the start of a DMA read cycle, a flag that the current cycle belongs to the DMA channel, and that cycle's T-state index.

The block produces a one-clock transfer-request pulse for each granted transfer, a burst-running status, a sticky transfer-end flag that software clears, and an active-low acknowledge that covers each DMA bus cycle. An edge-triggered burst is started by one falling edge and then ignores the pin until the end condition arrives. A level-triggered burst keeps checking the pin at bus-cycle boundaries and drops back to checking every state as soon as it finds the pin released.

Top module: `dma_req_sampler`

## Requirements
- R1: While and after reset, with no stimulus, xfer_req_o and burst_act_o and te_o are 0 and ack_n_o is 1.
- R2: req_n_i passes through a two-stage synchronizer and xfer_req_o is registered: a level set just before clock edge k is first acted on at edge k+2 and shows on xfer_req_o after that edge, never earlier.
- R3: With level detection (cfg_edge_i=0), a low synchronized pin at a sample point grants a transfer; outside a DMA cycle in cycle-steal mode a sample point is every clock with state_en_i=1, and a clock with state_en_i=0 is no sample point.
- R4: In burst mode with edge detection (cfg_burst_i=1, cfg_edge_i=1), a sample of 0 following a sample of 1 gives exactly one xfer_req_o pulse and sets burst_act_o.
- R5: While an edge-triggered burst runs, the pin is not sampled: no xfer_req_o pulse occurs whatever the pin does, and burst_act_o stays 1 until the end condition.
- R6: A clock with end_cond_i=1 clears burst_act_o and sets te_o at that edge, and grants no transfer in that clock.
- R7: While te_o is 1 no transfer is granted; te_clr_i clears te_o (end_cond_i wins if both are high). In edge mode the pin is still sampled every state while te_o is 1, so a fall seen during that time grants nothing and a fresh fall is needed after the clear.
- R8: In a level-triggered burst in single address mode (cfg_dual_i=0), once burst_act_o is 1 the pin is sampled only in clocks with cyc_end_i=1.
- R9: In a level-triggered burst in dual address mode (cfg_dual_i=1), once burst_act_o is 1 the pin is sampled only in clocks with rd_start_i=1; cyc_end_i has no effect.
- R10: In a level-triggered burst, a sample that finds the pin high clears burst_act_o, after which the pin is sampled every state.
- R11: In cycle-steal dual address mode, during a DMA cycle (dmac_cyc_i=1) the pin is sampled only in the state with tstate_i=1 (second state, T-states coded 0 to 3); a request released after that state still yields the transfer, and one arriving later waits until the DMA cycle ends. In cycle-steal single address mode the sample inside a DMA cycle is the clock with cyc_end_i=1.
- R12: ack_n_o goes low after a clock with cyc_start_i=1 and dmac_cyc_i=1, and returns high after a clock with cyc_end_i=1 (bus cycles last at least two clocks).
- R13: In cycle-steal mode (cfg_burst_i=0), burst_act_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_n_i | input | 1 | Asynchronous DMA request pin, active low |
| state_en_i | input | 1 | One-clock strobe per bus state |
| cfg_burst_i | input | 1 | 1 burst, 0 cycle-steal |
| cfg_edge_i | input | 1 | 1 falling-edge detection, 0 low-level detection |
| cfg_dual_i | input | 1 | 1 dual address, 0 single address |
| cyc_start_i | input | 1 | First clock of a bus cycle |
| cyc_end_i | input | 1 | Last clock of a bus cycle (CPU or DMA) |
| rd_start_i | input | 1 | First clock of a DMA read cycle |
| dmac_cyc_i | input | 1 | Current bus cycle is a DMA cycle |
| tstate_i | input | TS_W | T-state index within the current bus cycle |
| end_cond_i | input | 1 | Transfer end condition reached |
| te_clr_i | input | 1 | Software clear of the transfer-end flag |
| xfer_req_o | output | 1 | One-clock transfer grant pulse |
| burst_act_o | output | 1 | A burst is in progress |
| te_o | output | 1 | Sticky transfer-end flag |
| ack_n_o | output | 1 | Active-low acknowledge for a DMA bus cycle |

## Verification
A pin change is acted on at the third rising edge after it is driven, two edges for the synchronizer and one for the decision register, so xfer_req_o is due one clock later than the sample-point strobes and configuration that the same decision uses, which act at the first edge. burst_act_o, te_o and ack_n_o follow their strobes after one edge. The bench drives every input on the falling edge, steps a behavioural model at each rising edge, and compares all four outputs at the following falling edge; directed checks count edges from the drive point with these latencies, so a check for a late T-state request looks at the clock after the DMA cycle ends.

// File: rtl/dreq_pkg.sv
package dreq_pkg;

  // Static channel configuration, gathered from the top-level pins.
  typedef struct packed {
    logic burst;     // 1: burst, 0: cycle-steal
    logic edge_det;  // 1: falling edge, 0: low level
    logic dual;      // 1: dual address, 0: single address
  } dreq_cfg_t;

endpackage

// File: rtl/dreq_sync.sv
module dreq_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] pipe_q;
  logic [STAGES-1:0] pipe_d;

  always_comb begin
    pipe_d = {pipe_q[STAGES-2:0], d_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe_q <= {STAGES{RST_VAL}};
    end else begin
      pipe_q <= pipe_d;
    end
  end

  assign q_o = pipe_q[STAGES-1];

endmodule

// File: rtl/dreq_point.sv
module dreq_point
  import dreq_pkg::*;
#(
  parameter int TS_W      = 2,
  parameter int SAMPLE_TS = 1
) (
  input  dreq_cfg_t        cfg_i,
  input  logic             burst_act_i,
  input  logic             state_en_i,
  input  logic             cyc_end_i,
  input  logic             rd_start_i,
  input  logic             dmac_cyc_i,
  input  logic [TS_W-1:0]  tstate_i,
  output logic             samp_o
);

  localparam logic [TS_W-1:0] SAMPLE_CODE = TS_W'(SAMPLE_TS);

  logic at_sample_state;

  assign at_sample_state = state_en_i && (tstate_i == SAMPLE_CODE);

  always_comb begin
    samp_o = state_en_i;
    if (cfg_i.burst) begin
      if (cfg_i.edge_det) begin
        // running edge burst: pin not looked at
        samp_o = state_en_i && !burst_act_i;
      end else if (burst_act_i) begin
        samp_o = cfg_i.dual ? rd_start_i : cyc_end_i;
      end
    end else if (dmac_cyc_i) begin
      samp_o = cfg_i.dual ? at_sample_state : cyc_end_i;
    end
  end

endmodule

// File: rtl/dreq_detect.sv
module dreq_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic samp_i,
  input  logic edge_mode_i,
  input  logic pin_n_i,
  output logic hit_o
);

  logic prev_q;
  logic prev_d;

  always_comb begin
    prev_d = samp_i ? pin_n_i : prev_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b1;
    end else begin
      prev_q <= prev_d;
    end
  end

  assign hit_o = edge_mode_i ? (prev_q && !pin_n_i) : !pin_n_i;

endmodule

// File: rtl/dma_req_sampler.sv
module dma_req_sampler
  import dreq_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int TS_W        = 2,
  parameter int SAMPLE_TS   = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_n_i,
  input  logic            state_en_i,
  input  logic            cfg_burst_i,
  input  logic            cfg_edge_i,
  input  logic            cfg_dual_i,
  input  logic            cyc_start_i,
  input  logic            cyc_end_i,
  input  logic            rd_start_i,
  input  logic            dmac_cyc_i,
  input  logic [TS_W-1:0] tstate_i,
  input  logic            end_cond_i,
  input  logic            te_clr_i,
  output logic            xfer_req_o,
  output logic            burst_act_o,
  output logic            te_o,
  output logic            ack_n_o
);

  dreq_cfg_t cfg;
  logic      pin_sync_n;
  logic      samp;
  logic      hit;
  logic      grant;

  logic      xfer_q, xfer_d;
  logic      burst_q, burst_d;
  logic      te_q, te_d;
  logic      ack_q, ack_d;

  assign cfg = '{burst: cfg_burst_i, edge_det: cfg_edge_i, dual: cfg_dual_i};

  dreq_sync #(
    .STAGES  (SYNC_STAGES),
    .RST_VAL (1'b1)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (req_n_i),
    .q_o   (pin_sync_n)
  );

  dreq_point #(
    .TS_W      (TS_W),
    .SAMPLE_TS (SAMPLE_TS)
  ) u_point (
    .cfg_i       (cfg),
    .burst_act_i (burst_q),
    .state_en_i  (state_en_i),
    .cyc_end_i   (cyc_end_i),
    .rd_start_i  (rd_start_i),
    .dmac_cyc_i  (dmac_cyc_i),
    .tstate_i    (tstate_i),
    .samp_o      (samp)
  );

  dreq_detect u_detect (
    .clk         (clk),
    .rst_n       (rst_n),
    .samp_i      (samp),
    .edge_mode_i (cfg.edge_det),
    .pin_n_i     (pin_sync_n),
    .hit_o       (hit)
  );

  assign grant = samp && hit && !te_q && !end_cond_i;

  always_comb begin
    xfer_d  = grant;
    te_d    = te_q;
    burst_d = burst_q;
    ack_d   = ack_q;

    if (end_cond_i) begin
      te_d = 1'b1;
    end else if (te_clr_i) begin
      te_d = 1'b0;
    end

    if (!cfg.burst || end_cond_i) begin
      burst_d = 1'b0;
    end else if (grant) begin
      burst_d = 1'b1;
    end else if (!cfg.edge_det && burst_q && samp && !hit) begin
      burst_d = 1'b0;  // level burst found the pin released
    end

    if (cyc_start_i && dmac_cyc_i) begin
      ack_d = 1'b1;
    end else if (cyc_end_i) begin
      ack_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xfer_q  <= 1'b0;
      burst_q <= 1'b0;
      te_q    <= 1'b0;
      ack_q   <= 1'b0;
    end else begin
      xfer_q  <= xfer_d;
      burst_q <= burst_d;
      te_q    <= te_d;
      ack_q   <= ack_d;
    end
  end

  assign xfer_req_o  = xfer_q;
  assign burst_act_o = burst_q;
  assign te_o        = te_q;
  assign ack_n_o     = !ack_q;

endmodule

// File: rtl/dreq_checks.sv
module dreq_checks (
  input logic clk,
  input logic rst_n,
  input logic cfg_burst_i,
  input logic cfg_edge_i,
  input logic dmac_cyc_i,
  input logic cyc_start_i,
  input logic cyc_end_i,
  input logic end_cond_i,
  input logic xfer_req_o,
  input logic burst_act_o,
  input logic te_o,
  input logic ack_n_o
);

  assert_flag_blocks_req_R7 : assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req_o |-> $past(!te_o));

  assert_edge_burst_quiet_R5 : assert property (@(posedge clk) disable iff (!rst_n)
    ($past(burst_act_o) && $past(cfg_burst_i) && $past(cfg_edge_i)) |-> !xfer_req_o);

  assert_end_sets_flag_R6 : assert property (@(posedge clk) disable iff (!rst_n)
    $past(end_cond_i) |-> (te_o && !burst_act_o && !xfer_req_o));

  assert_ack_low_R12 : assert property (@(posedge clk) disable iff (!rst_n)
    $past(cyc_start_i && dmac_cyc_i) |-> !ack_n_o);

  assert_ack_high_R12 : assert property (@(posedge clk) disable iff (!rst_n)
    $past(cyc_end_i && !(cyc_start_i && dmac_cyc_i)) |-> ack_n_o);

  assert_steal_no_burst_R13 : assert property (@(posedge clk) disable iff (!rst_n)
    $past(!cfg_burst_i) |-> !burst_act_o);

endmodule

bind dma_req_sampler dreq_checks u_checks (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_burst_i (cfg_burst_i),
  .cfg_edge_i  (cfg_edge_i),
  .dmac_cyc_i  (dmac_cyc_i),
  .cyc_start_i (cyc_start_i),
  .cyc_end_i   (cyc_end_i),
  .end_cond_i  (end_cond_i),
  .xfer_req_o  (xfer_req_o),
  .burst_act_o (burst_act_o),
  .te_o        (te_o),
  .ack_n_o     (ack_n_o)
);

// File: tb/sim_dma_req_sampler.sv
`timescale 1ns/1ps
module sim_dma_req_sampler;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pin = 1'b1, st_en = 1'b1;
  logic       c_burst = 1'b0, c_edge = 1'b0, c_dual = 1'b1;
  logic       cstart = 1'b0, cend = 1'b0, rdst = 1'b0, dmac = 1'b0;
  logic [1:0] tst = 2'd0;
  logic       endc = 1'b0, teclr = 1'b0;
  logic       xfer, bact, te, ack_n;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dma_req_sampler u0 (
    .clk(clk), .rst_n(rst_n), .req_n_i(pin), .state_en_i(st_en),
    .cfg_burst_i(c_burst), .cfg_edge_i(c_edge), .cfg_dual_i(c_dual),
    .cyc_start_i(cstart), .cyc_end_i(cend), .rd_start_i(rdst),
    .dmac_cyc_i(dmac), .tstate_i(tst), .end_cond_i(endc), .te_clr_i(teclr),
    .xfer_req_o(xfer), .burst_act_o(bact), .te_o(te), .ack_n_o(ack_n)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference, stepped on each rising edge.
  bit sq[$];
  bit m_prev, m_xfer, m_bact, m_te, m_ack;

  always @(posedge clk) begin
    if (!rst_n) begin
      sq = '{1'b1, 1'b1};
      m_prev = 1; m_xfer = 0; m_bact = 0; m_te = 0; m_ack = 0;
    end else begin
      bit cur, smp, hitm, fire, nb, nte, nack;
      cur = sq[0];
      if (c_burst) begin
        if (c_edge)      smp = st_en && !m_bact;
        else if (m_bact) smp = c_dual ? rdst : cend;
        else             smp = st_en;
      end else if (dmac) begin
        smp = c_dual ? (st_en && tst == 2'd1) : cend;
      end else begin
        smp = st_en;
      end
      hitm = c_edge ? (m_prev && !cur) : !cur;
      fire = smp && hitm && !m_te && !endc;
      nte  = endc ? 1'b1 : (teclr ? 1'b0 : m_te);
      if (!c_burst || endc) nb = 0;
      else if (fire) nb = 1;
      else if (!c_edge && m_bact && smp && !hitm) nb = 0;
      else nb = m_bact;
      nack = (cstart && dmac) ? 1'b1 : (cend ? 1'b0 : m_ack);
      if (smp) m_prev = cur;
      m_xfer = fire; m_bact = nb; m_te = nte; m_ack = nack;
      sq.push_back(pin);
      void'(sq.pop_front());
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R3 model xfer_req", xfer, m_xfer);
      chk("R4 model burst_act", bact, m_bact);
      chk("R6 model te", te, m_te);
      chk("R12 model ack_n", ack_n, !m_ack);
    end
  end

  task automatic step();
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      done = 1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (4) step();
    rst_n = 1'b1;
    step();
    chk("R1 reset xfer_req", xfer, 0);
    chk("R1 reset burst_act", bact, 0);
    chk("R1 reset te", te, 0);
    chk("R1 reset ack_n", ack_n, 1);

    // R2 / R3: cycle-steal, level, idle
    pin = 0; step(); step();
    chk("R2 too early", xfer, 0);
    step();
    chk("R2 third edge", xfer, 1);
    step();
    chk("R3 level every state", xfer, 1);
    st_en = 0; step();
    chk("R3 no state strobe", xfer, 0);
    st_en = 1; pin = 1; repeat (4) step();
    chk("R3 released", xfer, 0);

    // R4 / R5: edge burst
    c_burst = 1; c_edge = 1; repeat (3) step();
    pin = 0; step(); step();
    chk("R4 not yet", xfer, 0);
    step();
    chk("R4 fall grants", xfer, 1);
    chk("R4 burst set", bact, 1);
    step();
    chk("R4 single pulse", xfer, 0);
    for (int i = 0; i < 8; i++) begin
      pin = ~pin; step();
      chk("R5 pin ignored", xfer, 0);
      chk("R5 burst held", bact, 1);
    end

    // R6 / R7
    endc = 1; step(); endc = 0;
    chk("R6 flag set", te, 1);
    chk("R6 burst cleared", bact, 0);
    pin = 1; repeat (4) step();
    pin = 0;
    for (int i = 0; i < 5; i++) begin
      step();
      chk("R7 blocked by flag", xfer, 0);
    end
    teclr = 1; step(); teclr = 0;
    chk("R7 flag cleared", te, 0);
    repeat (3) step();
    chk("R7 needs fresh fall", xfer, 0);
    pin = 1; repeat (4) step();
    pin = 0; repeat (3) step();
    chk("R7 fresh fall grants", xfer, 1);
    endc = 1; pin = 1; step(); endc = 0;
    teclr = 1; step(); teclr = 0;
    repeat (3) step();

    // R8 / R10: level burst, single address
    c_edge = 0; c_dual = 0; step();
    chk("R10 idle", bact, 0);
    pin = 0; repeat (3) step();
    chk("R8 level grants", xfer, 1);
    chk("R8 burst set", bact, 1);
    step();
    chk("R8 waits for cycle end", xfer, 0);
    pin = 1; repeat (5) step();
    chk("R8 no sample yet", bact, 1);
    cend = 1; step(); cend = 0;
    chk("R10 miss clears burst", bact, 0);
    pin = 0; repeat (3) step();
    chk("R10 every state again", xfer, 1);
    step();
    chk("R8 quiet between ends", xfer, 0);
    cend = 1; step(); cend = 0;
    chk("R8 cycle end sample", xfer, 1);

    // R9: level burst, dual address
    c_dual = 1; step();
    chk("R9 no read start", xfer, 0);
    cend = 1; step(); cend = 0;
    chk("R9 cycle end ignored", xfer, 0);
    rdst = 1; step(); rdst = 0;
    chk("R9 read start sample", xfer, 1);

    // R11 / R12 / R13: cycle-steal dual
    c_burst = 0; step();
    chk("R13 steal no burst", bact, 0);
    dmac = 1; tst = 0; cstart = 1; rdst = 1; step();
    chk("R12 ack low", ack_n, 0);
    chk("R11 T1 not sampled", xfer, 0);
    cstart = 0; rdst = 0; tst = 1; pin = 1; step();
    chk("R11 T2 sample", xfer, 1);
    tst = 2; step();
    chk("R11 T3 quiet", xfer, 0);
    tst = 3; cend = 1; step();
    chk("R11 T4 quiet", xfer, 0);
    chk("R12 ack high", ack_n, 1);
    dmac = 0; cend = 0; tst = 0; step();
    chk("R11 released", xfer, 0);
    dmac = 1; cstart = 1; step();
    cstart = 0; tst = 1; pin = 0; step();
    chk("R11 T2 high", xfer, 0);
    tst = 2; step();
    tst = 3; cend = 1; step();
    chk("R11 late request waits", xfer, 0);
    dmac = 0; cend = 0; tst = 0; step();
    chk("R11 after cycle", xfer, 1);
    chk("R13 still no burst", bact, 0);

    // mixed stimulus against the model
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0, 5) == 0) pin = ~pin;
      st_en  = ($urandom_range(0, 3) != 0);
      cstart = ($urandom_range(0, 5) == 0);
      cend   = !cstart && ($urandom_range(0, 5) == 0);
      rdst   = ($urandom_range(0, 4) == 0);
      dmac   = ($urandom_range(0, 2) == 0);
      tst    = 2'($urandom_range(0, 3));
      endc   = ($urandom_range(0, 40) == 0);
      teclr  = ($urandom_range(0, 15) == 0);
      if ($urandom_range(0, 200) == 0) begin
        c_burst = 1'($urandom_range(0, 1));
        c_edge  = 1'($urandom_range(0, 1));
        c_dual  = 1'($urandom_range(0, 1));
      end
      step();
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule